// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block connects a synchronous request interface to an external asynchronous static RAM of 256K one-byte locations. A client raises a request carrying an 18-bit address, a direction flag and, for stores, one data byte. The controller then runs a complete memory access on the pins. It sets up the address and the two chip selects, pulses the write strobe or the output enable, holds the bus and releases it. At the end it answers with a one-cycle `ready`. Loads also return the fetched byte with a one-cycle `rd_valid` pulse.

The time each phase lasts is fixed at elaboration. Each nanosecond minimum of the memory is divided by the clock period and rounded up to whole clock cycles. The speed grade is set by the parameter `GRADE`: 0 is the 35 ns part, 1 the 45 ns part and 2 the 55 ns part. The memory data pins are split into an output byte, an input byte and an output-enable. A pad ring outside this block combines them. The controller only drives the bus after the memory has released it.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is low, and in the cycle after it, the controller holds these values: `mem_ce_n`=1, `mem_ce`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0, `ready`=0 and `rd_valid`=0.
- R2: The memory counts as selected only when `mem_ce_n`=0 and `mem_ce`=1. Whenever `mem_we_n` or `mem_oe_n` is low, the memory is selected. Between accesses, both selects are inactive.
- R3: A store drives `mem_we_n` low for WR_STB cycles. WR_STB is the largest of these values, each divided by the clock period and rounded up: the write pulse minimum (30/35/40 ns), the address-to-write-end minimum (25/35/45 ns) and the data setup (15/20/25 ns). For GRADE 0 at 10 ns, WR_STB is 3. The data byte is driven for the whole pulse. The write ends with the rise of `mem_we_n`. Address, selects and data stay unchanged at that edge.
- R4: A load drives `mem_oe_n` low for RD_STB cycles. RD_STB is the larger of the address access time (35/45/55 ns) and the output-enable access time (15/20/25 ns), each rounded up to whole cycles. For GRADE 0 at 10 ns, RD_STB is 4. The byte on `mem_dq_in` is captured at the clock edge that ends the output-enable pulse.
- R5: After a load, `rd_valid` is high for exactly one cycle. During that cycle `mem_oe_n` is high and `rd_data` holds the captured byte.
- R6: The controller never drives the bus while `mem_oe_n` is low. It also does not drive the bus until the output-enable release time (10/15/20 ns) after `mem_oe_n` rises. That time is covered by TA (at least one cycle).
- R7: `ready` is high for exactly one cycle per access. Cycle 1 begins at the edge that accepts the request. `ready` falls in cycle 2+WR_STB for a store and in cycle 2+RD_STB+TA for a load (5 and 7 at the defaults).
- R8: A request is accepted only when the controller is idle. Changes to `req_addr`, `req_wdata` or `req_wr` during an access are ignored. The pins keep the accepted address, and the accepted byte is the one stored.
- R9: The chip selects stay active for at least the cycle time of the grade (35/45/55 ns) in every access.
- R10: `mem_we_n` and `mem_oe_n` are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request, sampled when idle |
| req_wr | input | 1 | 1 = store, 0 = load |
| req_addr | input | 18 | Byte address |
| req_wdata | input | 8 | Store data |
| ready | output | 1 | One-cycle access-complete pulse |
| rd_valid | output | 1 | One-cycle load-data pulse |
| rd_data | output | 8 | Captured load data |
| mem_addr | output | 18 | Memory address bus |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_ce | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Data driven to the memory |
| mem_dq_in | input | 8 | Data returned by the memory |
| mem_dq_oe | output | 1 | Enables the data bus driver |

## Verification
The bench places a memory model on the pins. The model answers loads with a marker byte until both access times have passed, so a strobe that is too short returns wrong data. The model also measures the write pulse width, the data setup, the address setup and the select time in nanoseconds. It flags any bus drive that overlaps the memory's own output, or its release window after `mem_oe_n` rises. A missing turnaround or too short a release would show up here. One directed case changes the request fields in the middle of an access. A controller that re-sampled its inputs would then store at the wrong address or store the wrong byte. Latency is counted per access to catch counts that are off by one cycle.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
// Shared types and elaboration-time timing math for the asynchronous SRAM
// controller. Assumes GRADE 0/1/2 selects the 35/45/55 ns part.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_STROBE = 3'd2,
        ST_HOLD   = 3'd3,
        ST_TURN   = 3'd4
    } sram_state_e;

    function automatic int unsigned ceil_div(int unsigned ns, int unsigned per);
        return (ns + per - 1) / per;
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Cycle time (also the address access time) per grade.
    function automatic int unsigned ns_cycle(int unsigned g);
        case (g)
            0:       return 35;
            1:       return 45;
            default: return 55;
        endcase
    endfunction

    function automatic int unsigned ns_we_pulse(int unsigned g);
        case (g)
            0:       return 30;
            1:       return 35;
            default: return 40;
        endcase
    endfunction

    // Address (and select) setup to write end.
    function automatic int unsigned ns_addr_to_end(int unsigned g);
        case (g)
            0:       return 25;
            1:       return 35;
            default: return 45;
        endcase
    endfunction

    // Data setup to write end; the output-enable access time has the same values.
    function automatic int unsigned ns_data_setup(int unsigned g);
        case (g)
            0:       return 15;
            1:       return 20;
            default: return 25;
        endcase
    endfunction

    function automatic int unsigned ns_oe_release(int unsigned g);
        case (g)
            0:       return 10;
            1:       return 15;
            default: return 20;
        endcase
    endfunction

    function automatic int unsigned wr_strobe_cycles(int unsigned g, int unsigned per);
        int unsigned c;
        int unsigned cyc;
        c   = max2(ceil_div(ns_we_pulse(g), per),
                   max2(ceil_div(ns_addr_to_end(g), per), ceil_div(ns_data_setup(g), per)));
        cyc = ceil_div(ns_cycle(g), per);
        if (cyc > c + 2) c = cyc - 2;
        return max2(c, 1);
    endfunction

    function automatic int unsigned rd_strobe_cycles(int unsigned g, int unsigned per);
        return max2(1, max2(ceil_div(ns_cycle(g), per), ceil_div(ns_data_setup(g), per)));
    endfunction

    function automatic int unsigned turn_cycles(int unsigned g, int unsigned per);
        return max2(1, ceil_div(ns_oe_release(g), per));
    endfunction

endpackage

// File: rtl/sram_seq.sv
`timescale 1ns/1ps
// Access sequencer: accepts one request while idle, walks setup, strobe,
// hold and turnaround phases with a down-counter, captures load data and
// raises the user-side pulses. Assumes phase lengths are at least one cycle.
module sram_seq
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W = 18,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned WR_STB = 3,
    parameter int unsigned RD_STB = 4,
    parameter int unsigned TA_CYC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output sram_state_e       st_nxt,
    output logic              wr_nxt,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    localparam int unsigned CNT_MAX = max2(WR_STB, max2(RD_STB, TA_CYC));
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_STB - 1);
    localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_STB - 1);
    localparam logic [CNT_W-1:0] TA_LOAD = CNT_W'(TA_CYC - 1);

    sram_state_e      st_q;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             wr_q;
    logic             capture;
    logic             accept;
    logic [DATA_W-1:0] rd_q;

    assign accept = (st_q == ST_IDLE) && req;

    // Next-phase and counter decode.
    always_comb begin
        st_nxt  = st_q;
        cnt_d   = cnt_q;
        wr_nxt  = wr_q;
        capture = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (req) begin
                    st_nxt = ST_SETUP;
                    wr_nxt = req_wr;
                end
            end
            ST_SETUP: begin
                st_nxt = ST_STROBE;
                cnt_d  = wr_q ? WR_LOAD : RD_LOAD;
            end
            ST_STROBE: begin
                if (cnt_q == '0) begin
                    st_nxt  = ST_HOLD;
                    capture = !wr_q;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_HOLD: begin
                if (wr_q) begin
                    st_nxt = ST_IDLE;
                end else begin
                    st_nxt = ST_TURN;
                    cnt_d  = TA_LOAD;
                end
            end
            ST_TURN: begin
                if (cnt_q == '0) st_nxt = ST_IDLE;
                else             cnt_d  = cnt_q - 1'b1;
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // Phase, counter and direction registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            wr_q  <= 1'b0;
        end else begin
            st_q  <= st_nxt;
            cnt_q <= cnt_d;
            wr_q  <= wr_nxt;
        end
    end

    // Request fields, latched only at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Load data capture at the edge that closes the output-enable pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_q <= '0;
        else if (capture) rd_q <= mem_rdata;
    end

    assign rd_data  = rd_q;
    assign rd_valid = (st_q == ST_HOLD) && !wr_q;
    assign ready    = ((st_q == ST_HOLD) && wr_q) ||
                      ((st_q == ST_TURN) && (cnt_q == '0));

endmodule

// File: rtl/sram_pins.sv
`timescale 1ns/1ps
// Pin stage: registers the memory control strobes from the next phase so
// every strobe leaves a flop and cannot glitch. Assumes the sequencer supplies
// next-phase and next-direction decode.
module sram_pins
    import sram_ctrl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  sram_state_e st_nxt,
    input  logic        wr_nxt,
    output logic        ce_n,
    output logic        ce,
    output logic        we_n,
    output logic        oe_n,
    output logic        dq_oe
);

    logic sel_d, we_d, oe_d, drv_d;

    // Strobe decode from the phase the sequencer enters next.
    always_comb begin
        sel_d = (st_nxt == ST_SETUP) || (st_nxt == ST_STROBE) || (st_nxt == ST_HOLD);
        we_d  = (st_nxt == ST_STROBE) && wr_nxt;
        oe_d  = (st_nxt == ST_STROBE) && !wr_nxt;
        drv_d = ((st_nxt == ST_STROBE) || (st_nxt == ST_HOLD)) && wr_nxt;
    end

    // Pin registers, inactive under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_n  <= 1'b1;
            ce    <= 1'b0;
            we_n  <= 1'b1;
            oe_n  <= 1'b1;
            dq_oe <= 1'b0;
        end else begin
            ce_n  <= !sel_d;
            ce    <= sel_d;
            we_n  <= !we_d;
            oe_n  <= !oe_d;
            dq_oe <= drv_d;
        end
    end

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
// Top of the asynchronous SRAM controller. Derives the phase lengths from the
// clock period and speed grade, and joins the sequencer and pin stage.
// Assumes an external pad combines mem_dq_out, mem_dq_oe and mem_dq_in.
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W = 18,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CLK_NS = 10,
    parameter int unsigned GRADE  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_ce,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);

    localparam int unsigned WR_STB = wr_strobe_cycles(GRADE, CLK_NS);
    localparam int unsigned RD_STB = rd_strobe_cycles(GRADE, CLK_NS);
    localparam int unsigned TA_CYC = turn_cycles(GRADE, CLK_NS);

    sram_state_e st_nxt;
    logic        wr_nxt;

    sram_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .WR_STB (WR_STB),
        .RD_STB (RD_STB),
        .TA_CYC (TA_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_wr    (req_wr),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .mem_rdata (mem_dq_in),
        .st_nxt    (st_nxt),
        .wr_nxt    (wr_nxt),
        .addr_q    (mem_addr),
        .wdata_q   (mem_dq_out),
        .ready     (ready),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    sram_pins u_pins (
        .clk    (clk),
        .rst_n  (rst_n),
        .st_nxt (st_nxt),
        .wr_nxt (wr_nxt),
        .ce_n   (mem_ce_n),
        .ce     (mem_ce),
        .we_n   (mem_we_n),
        .oe_n   (mem_oe_n),
        .dq_oe  (mem_dq_oe)
    );

endmodule

// File: rtl/sram_ctrl_chk.sv
`timescale 1ns/1ps
// Protocol checker for the asynchronous SRAM controller pins, bound to the top.
module sram_ctrl_chk #(
    parameter int unsigned ADDR_W = 18,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_ce,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe
);

    AST_RESET_INACTIVE: assert property (@(posedge clk) !rst_n |=> (mem_ce_n && !mem_ce && mem_we_n && mem_oe_n && !mem_dq_oe && !ready && !rd_valid)); // R1
    AST_WE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n) !mem_we_n |-> (!mem_ce_n && mem_ce)); // R2
    AST_OE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n) !mem_oe_n |-> (!mem_ce_n && mem_ce)); // R2
    AST_WE_DATA_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n) !mem_we_n |-> mem_dq_oe); // R3
    AST_WR_END_HELD: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_dq_out) && $stable(mem_addr) && !mem_ce_n)); // R3
    AST_STROBE_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (!mem_we_n || !mem_oe_n) |-> $stable(mem_addr)); // R4
    AST_VALID_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> mem_oe_n); // R5
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |=> !rd_valid); // R5
    AST_NO_DRIVE_OE_LOW: assert property (@(posedge clk) disable iff (!rst_n) mem_dq_oe |-> mem_oe_n); // R6
    AST_NO_DRIVE_AT_OE_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_oe_n) |-> !mem_dq_oe); // R6
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n) ready |=> !ready); // R7
    AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !mem_oe_n |-> mem_we_n); // R10

endmodule

bind sram_async_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_sram_async_ctrl.sv
`timescale 1ns/1ps
module tb_sram_async_ctrl;

    localparam int CLK_NS = 10;
    // Grade 0 minimums in ns, from the requirements.
    localparam int T_PWE = 30, T_AW = 25, T_SD = 15, T_AA = 35, T_DOE = 15;
    localparam int T_HZOE = 10, T_CYC = 35;

    function automatic int cdiv(int ns); return (ns + CLK_NS - 1) / CLK_NS; endfunction
    function automatic int imax(int a, int b); return (a > b) ? a : b; endfunction
    function automatic int exp_wr_stb(); return imax(cdiv(T_PWE), imax(cdiv(T_AW), cdiv(T_SD))); endfunction
    function automatic int exp_rd_stb(); return imax(cdiv(T_AA), cdiv(T_DOE)); endfunction
    function automatic int exp_ta(); return imax(1, cdiv(T_HZOE)); endfunction
    function automatic int exp_lat(bit wr);
        return wr ? 2 + exp_wr_stb() : 2 + exp_rd_stb() + exp_ta();
    endfunction

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, req_wr = 1'b0;
    logic [17:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ready, rd_valid;
    logic [7:0]  rd_data;
    logic [17:0] mem_addr;
    logic        mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = '0;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #(CLK_NS/2) clk = ~clk;

    sram_async_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
        .req_wdata(req_wdata), .ready(ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
        .mem_dq_oe(mem_dq_oe)
    );

    task automatic check(bit ok, string rq, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // ---------------- memory model on the pins ----------------
    logic [7:0] sram [int];
    logic [7:0] refm [int];
    time t_addr = 0, t_oe_fall = 0, t_oe_rise = 0, t_we_fall = 0, t_dq = 0, t_cs = 0;
    bit  cs_seen = 0;
    wire sel = !mem_ce_n && mem_ce;

    always @(mem_addr) t_addr = $time;
    always @(negedge mem_oe_n) t_oe_fall = $time;
    always @(posedge mem_oe_n) t_oe_rise = $time;
    always @(negedge mem_we_n) t_we_fall = $time;
    always @(mem_dq_out or mem_dq_oe) t_dq = $time;
    always @(negedge mem_ce_n) begin t_cs = $time; cs_seen = 1; end

    // R9: select time per access.
    always @(posedge mem_ce_n) begin
        if (cs_seen && rst_n) check(($time - t_cs) >= T_CYC, "R9 select time ns", $time - t_cs, T_CYC);
    end

    // R3: write commit and write timing at the end of the pulse.
    always @(posedge mem_we_n) begin
        if (rst_n && sel) begin
            check(($time - t_we_fall) >= T_PWE, "R3 write pulse ns", $time - t_we_fall, T_PWE);
            check(($time - t_dq) >= T_SD, "R3 data setup ns", $time - t_dq, T_SD);
            check(($time - t_addr) >= T_AW, "R3 address setup ns", $time - t_addr, T_AW);
            check(mem_dq_oe == 1'b1, "R3 data driven at write end", mem_dq_oe, 1);
            sram[int'(mem_addr)] = mem_dq_out;
        end
    end

    // Load data, contention (R6), selection (R2) and exclusion (R10).
    always @(negedge clk) begin
        bit drive_mem;
        bit linger;
        drive_mem = sel && !mem_oe_n && mem_we_n;
        linger    = (t_oe_rise != 0) && (($time - t_oe_rise) < T_HZOE);
        if (rst_n) begin
            if (mem_dq_oe) check(!(drive_mem || linger), "R6 bus contention", 1, 0);
            if (!mem_we_n || !mem_oe_n) check(sel, "R2 strobe without select", sel, 1);
            if (!mem_oe_n) check(mem_we_n, "R10 WE and OE both low", mem_we_n, 1);
        end
        if (drive_mem && (($time + 5 - t_addr) >= T_AA) && (($time + 5 - t_oe_fall) >= T_DOE))
            mem_dq_in = sram.exists(int'(mem_addr)) ? sram[int'(mem_addr)] : 8'h00;
        else
            mem_dq_in = 8'hEE;
    end

    // ---------------- one access with latency and pulse checks ----------------
    task automatic do_op(bit wr, logic [17:0] a, logic [7:0] d, bit poke);
        int cyc = 0;
        int vcnt = 0;
        logic [7:0] vdata = '0;
        logic [7:0] expd;
        expd = refm.exists(int'(a)) ? refm[int'(a)] : 8'h00;
        req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
        while (1) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 1) begin
                req_addr = ~a; req_wdata = ~d; req_wr = !wr;   // R8: must be ignored
            end
            if (sel) check(mem_addr == a, "R8 address held", mem_addr, a);
            if (rd_valid) begin vcnt++; vdata = rd_data; check(mem_oe_n, "R5 OE high at valid", mem_oe_n, 1); end
            if (ready || cyc > 40) break;
        end
        req = 1'b0;
        check(cyc == exp_lat(wr), wr ? "R7 store latency" : "R7 load latency", cyc, exp_lat(wr));
        @(negedge clk);
        check(ready == 1'b0, "R7 ready one cycle", ready, 0);
        if (wr) begin
            refm[int'(a)] = d;
            check(vcnt == 0, "R5 no valid on store", vcnt, 0);
        end else begin
            check(vcnt == 1, "R5 valid pulse count", vcnt, 1);
            check(vdata == expd, "R4 load data", vdata, expd);
        end
    endtask

    initial begin
        #(200000 * CLK_NS);
        if (!done) begin
            check(0, "watchdog", 0, 1);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        // R1: reset state.
        check({mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe, ready, rd_valid} == 7'b1011000,
              "R1 reset pins", {mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe, ready, rd_valid}, 7'b1011000);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_ce_n && !mem_ce && !mem_dq_oe, "R1 idle after reset", {mem_ce_n, mem_ce, mem_dq_oe}, 3'b100);

        // Directed corners: address extremes, all-zero and all-one bytes.
        do_op(1'b1, 18'h00000, 8'hFF, 0);
        do_op(1'b1, 18'h3FFFF, 8'h00, 0);
        do_op(1'b0, 18'h00000, 8'h00, 0);
        do_op(1'b0, 18'h3FFFF, 8'h00, 0);
        do_op(1'b0, 18'h12345, 8'h00, 0);           // never written
        do_op(1'b1, 18'h00001, 8'h5A, 1);           // R8: fields change mid-store
        do_op(1'b0, 18'h00001, 8'h00, 1);           // R8: fields change mid-load
        do_op(1'b0, ~18'h00001, 8'h00, 0);          // poked address untouched
        do_op(1'b1, 18'h00002, 8'hC3, 0);
        do_op(1'b0, 18'h00002, 8'h00, 0);           // load right after store
        do_op(1'b1, 18'h00002, 8'h3C, 0);           // store right after load (R6)

        // Random mix over a small address window to revisit locations.
        for (int i = 0; i < 120; i++) begin
            logic [17:0] a;
            a = ($urandom_range(0, 3) == 0) ? 18'($urandom) : 18'(18'h20000 + $urandom_range(0, 15));
            do_op(1'($urandom_range(0, 1)), a, 8'($urandom), 1'($urandom_range(0, 7) == 0));
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule